// File: doc/BRIEF.md
# Strap-Configured Serial Register Port

This block is a serial slave that lets an external master read and write a byte-wide register file. It is used in place of a parallel host bus. The master drives a serial clock, a data line into the slave and a chip select, and the slave answers on one data output that has its own enable. Clock polarity, clock phase, chip-select level and the way the output enable behaves are not set by software. They are strap inputs that the block captures while reset is held.

The serial port is active only when a particular strap combination is present at reset. Otherwise it stays silent. The three serial inputs pass through synchronizers into the system clock domain, and the block detects the serial clock edges there.

A transaction begins with one command byte and continues with any number of data bytes. The command byte carries a direction bit and a 7-bit start address. Each data byte then reaches the next address, and the address wraps at the top of the space. The register file is external to the block and has a combinational read port and a single-cycle write strobe.

Top module: `spi_regport`

## Requirements
- R1: The serial port is enabled only when, during reset, `mode_sel` is 2'b00 and both `rd_n` and `wr_n` are low. If it is not enabled, `reg_we` never pulses and `miso_oe` stays low.
- R2: The straps `mode_sel`, `rd_n`, `wr_n`, `strap_cpol`, `strap_cpha`, `strap_cs_high` and `strap_ste` are captured only while `rst_n` is low. Changing them later has no effect.
- R3: The idle level of `sclk` equals the captured `strap_cpol`, and the leading edge is the transition away from that level. With `strap_cpha`=0, the slave samples `mosi` on leading edges and changes `miso` on trailing edges. With `strap_cpha`=1, it changes `miso` on leading edges and samples on trailing edges.
- R4: `cs_pin` is active at the level given by the captured `strap_cs_high` (1 = active high). Serial clock activity while `cs_pin` is at the other level has no effect.
- R5: Bytes travel most significant bit first. In the first byte of a selection, bit 7 is the direction (1 = read, 0 = write) and bits 6:0 are the start address.
- R6: In a write, each complete data byte causes exactly one single-cycle `reg_we` pulse, with `reg_addr` set to the current address and `reg_wdata` set to the byte.
- R7: After each data byte the address goes up by one, and it wraps from 7'h7F to 7'h00.
- R8: In a read, the data bytes on `miso` are the register contents at the start address and then the following addresses. During the command byte `miso` carries zeros.
- R9: `miso_oe` is low as soon as `cs_pin` is inactive. While selected, `miso_oe` is high throughout if `strap_ste`=0. If `strap_ste`=1, it is high only after the command byte has completed.
- R10: If chip select goes inactive part way through a byte, that byte is discarded with no write. The next selection starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| mode_sel | input | 2 | Interface mode strap |
| rd_n | input | 1 | Read strobe strap, low to select serial mode |
| wr_n | input | 1 | Write strobe strap, low to select serial mode |
| strap_cpol | input | 1 | Idle serial clock level |
| strap_cpha | input | 1 | Clock phase select |
| strap_cs_high | input | 1 | 1: chip select active high, 0: active low |
| strap_ste | input | 1 | 1: hold output disabled during the command byte |
| sclk | input | 1 | Serial clock from master |
| mosi | input | 1 | Serial data from master |
| cs_pin | input | 1 | Chip select |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for `miso` (low = high impedance) |
| reg_addr | output | 7 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write strobe |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |

## Verification
The hardest case to reach is a chip select that is withdrawn part way through a byte. This is harmful only if a stale bit count or direction flag survives into the next selection. The stimulus aborts once inside a command byte and once inside a write data byte. It then runs a full transaction right away and checks that this transaction is aligned and that the aborted byte never reached the register file. Every pairing of polarity, phase and select level is reached by capturing new straps in a fresh reset. Random bursts then run over each pairing, one of them crossing the address wrap.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          strap_cpol,
  input  logic          strap_cpha,
  input  logic          strap_cs_high,
  input  logic          strap_ste,
  input  logic          sclk,
  input  logic          mosi,
  input  logic          cs_pin,
  output logic          miso,
  output logic          miso_oe,
  output logic [DW-2:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int AW = DW - 1;
  localparam int CW = $clog2(DW);

  logic en_q, cpol_q, cpha_q, csh_q, ste_q;
  logic [SYNC:0]   sclk_p;
  logic [SYNC-1:0] mosi_p, cs_p;
  logic [CW-1:0]   bitcnt;
  logic [DW-1:0]   rx_sr, tx_sr, wdata_q;
  logic [AW-1:0]   ptr;
  logic miso_q, in_data, is_read, byte_done, load_pend, we_q;
  logic cs_raw, cs_s, rise, fall, lead, trail, samp, shft;

  always_ff @(posedge clk)
    if (!rst_n) begin
      en_q   <= (mode_sel == 2'b00) && !rd_n && !wr_n;
      cpol_q <= strap_cpol;
      cpha_q <= strap_cpha;
      csh_q  <= strap_cs_high;
      ste_q  <= strap_ste;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      sclk_p <= '0;
      mosi_p <= '0;
      cs_p   <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC-1:0], sclk};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
      cs_p   <= {cs_p[SYNC-2:0], cs_raw};
    end

  assign cs_raw = en_q && (cs_pin == csh_q);
  assign cs_s   = cs_p[SYNC-1];
  assign rise   = sclk_p[SYNC-1] & ~sclk_p[SYNC];
  assign fall   = ~sclk_p[SYNC-1] & sclk_p[SYNC];
  assign lead   = cpol_q ? fall : rise;
  assign trail  = cpol_q ? rise : fall;
  assign samp   = cs_s && (cpha_q ? trail : lead);
  assign shft   = cs_s && (cpha_q ? lead : trail);

  always_ff @(posedge clk)
    if (!rst_n) begin
      bitcnt    <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      wdata_q   <= '0;
      ptr       <= '0;
      miso_q    <= 1'b0;
      in_data   <= 1'b0;
      is_read   <= 1'b0;
      byte_done <= 1'b0;
      load_pend <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      if (we_q) begin
        we_q <= 1'b0;
        ptr  <= ptr + 1'b1;
      end
      if (!cs_s) begin
        bitcnt    <= '0;
        in_data   <= 1'b0;
        is_read   <= 1'b0;
        tx_sr     <= '0;
        miso_q    <= 1'b0;
        byte_done <= 1'b0;
        load_pend <= 1'b0;
      end else begin
        byte_done <= 1'b0;
        if (samp) begin
          rx_sr     <= {rx_sr[DW-2:0], mosi_p[SYNC-1]};
          bitcnt    <= (bitcnt == CW'(DW-1)) ? '0 : bitcnt + 1'b1;
          byte_done <= (bitcnt == CW'(DW-1));
        end
        if (shft) begin
          if (cpha_q) begin
            miso_q <= tx_sr[DW-1];
            tx_sr  <= tx_sr << 1;
          end else if (bitcnt != '0) begin
            tx_sr  <= tx_sr << 1;
          end
        end
        if (byte_done) begin
          if (!in_data) begin
            in_data   <= 1'b1;
            is_read   <= rx_sr[DW-1];
            ptr       <= rx_sr[AW-1:0];
            load_pend <= rx_sr[DW-1];
          end else if (is_read) begin
            load_pend <= 1'b1;
          end else begin
            we_q    <= 1'b1;
            wdata_q <= rx_sr;
          end
        end
        if (load_pend) begin
          load_pend <= 1'b0;
          tx_sr     <= reg_rdata;
          ptr       <= ptr + 1'b1;
        end
      end
    end

  assign miso      = cpha_q ? miso_q : tx_sr[DW-1];
  assign miso_oe   = cs_raw && (!ste_q || in_data);
  assign reg_addr  = ptr;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;

  a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == AW'($past(reg_addr) + 1'b1));
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !reg_we && !miso_oe);
  a_r2_straps_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable({en_q, cpol_q, cpha_q, csh_q, ste_q}));
  a_r10_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> bitcnt == '0 && !in_data);
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
  localparam int H = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, rd_n, wr_n, s_cpol, s_cpha, s_csh, s_ste;
  logic [1:0] mode_sel;
  logic       sclk, mosi, cs_pin, miso, miso_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rd_n(rd_n), .wr_n(wr_n),
    .strap_cpol(s_cpol), .strap_cpha(s_cpha), .strap_cs_high(s_csh), .strap_ste(s_ste),
    .sclk(sclk), .mosi(mosi), .cs_pin(cs_pin), .miso(miso), .miso_oe(miso_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  int we_count = 0;
  always @(posedge clk) if (reg_we) begin mem[reg_addr] <= reg_wdata; we_count++; end
  assign reg_rdata = mem[reg_addr];

  int checks = 0, fails = 0;
  logic cur_cpol, cur_cpha, cur_csh, cur_ste;
  logic [7:0] tx_buf [8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expect_at(input logic [6:0] a);
    return exp_mem[a];
  endfunction

  task automatic do_reset(input bit en, input bit cpol, input bit cpha, input bit csh, input bit ste);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = 2'b00; rd_n = !en; wr_n = 1'b0;
    s_cpol = cpol; s_cpha = cpha; s_csh = csh; s_ste = ste;
    cur_cpol = cpol; cur_cpha = cpha; cur_csh = csh; cur_ste = ste;
    sclk = cpol; mosi = 1'b0; cs_pin = !csh;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
  endtask

  task automatic xfer(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      if (!cur_cpha) begin
        mosi = b[i]; wait_clk(H);
        r[i] = miso; sclk = !cur_cpol; wait_clk(H);
        sclk = cur_cpol;
      end else begin
        sclk = !cur_cpol; mosi = b[i]; wait_clk(H);
        r[i] = miso; sclk = cur_cpol; wait_clk(H);
      end
    end
    wait_clk(H);
  endtask

  task automatic cs_on();
    cs_pin = cur_csh;
    wait_clk(H);
    check(miso_oe == !cur_ste, "R9", miso_oe, !cur_ste);
  endtask

  task automatic cs_off();
    wait_clk(H);
    cs_pin = !cur_csh;
    @(negedge clk);
    check(miso_oe == 1'b0, "R9", miso_oe, 0);
    wait_clk(2*H);
  endtask

  task automatic write_burst(input logic [6:0] a, input int n);
    logic [7:0] r;
    int w0;
    w0 = we_count;
    cs_on();
    xfer({1'b0, a}, 8, r);
    for (int i = 0; i < n; i++) begin
      xfer(tx_buf[i], 8, r);
      exp_mem[7'(a + i)] = tx_buf[i];
    end
    cs_off();
    check(we_count - w0 == n, "R6", we_count - w0, n);
  endtask

  task automatic read_burst(input logic [6:0] a, input int n, input string req);
    logic [7:0] r;
    cs_on();
    xfer({1'b1, a}, 8, r);
    check(r == 8'h00, "R8", r, 0);
    check(miso_oe == 1'b1, "R9", miso_oe, 1);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, r);
      check(r == expect_at(7'(a + i)), req, r, expect_at(7'(a + i)));
    end
    cs_off();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int w0, n;
    logic [6:0] a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'($urandom);
      exp_mem[i] = mem[i];
    end

    // R1 reset state with serial enabled
    do_reset(1, 0, 0, 0, 0);
    check(miso_oe == 1'b0 && reg_we == 1'b0, "R1", {miso_oe, reg_we}, 0);

    // R3 R4 all polarity/phase/select combinations, random bursts
    for (int c = 0; c < 8; c++) begin
      do_reset(1, c[0], c[1], c[2], 1'($urandom));
      w0 = we_count;
      for (int k = 0; k < 8; k++) begin
        mosi = 1'($urandom); sclk = !sclk; wait_clk(H);
      end
      sclk = cur_cpol; wait_clk(H);
      check(we_count == w0, "R4", we_count - w0, 0);
      a = 7'($urandom); n = 1 + ($urandom % 5);
      for (int i = 0; i < n; i++) tx_buf[i] = 8'($urandom);
      write_burst(a, n);
      read_burst(a, n, "R3");
    end

    // R5 single write lands at the commanded address
    do_reset(1, 0, 0, 0, 0);
    a = 7'h35; tx_buf[0] = 8'hA6;
    write_burst(a, 1);
    wait_clk(2);
    check(mem[a] == 8'hA6, "R5", mem[a], 8'hA6);

    // R7 wrap from 7F to 00
    for (int i = 0; i < 4; i++) tx_buf[i] = 8'(8'h51 + i);
    write_burst(7'h7E, 4);
    read_burst(7'h7E, 4, "R7");
    check(mem[0] == 8'h53, "R7", mem[0], 8'h53);

    // R2 strap pins change after reset: captured config still applies
    do_reset(1, 1, 1, 1, 1);
    s_cpol = 0; s_cpha = 0; s_csh = 0; s_ste = 0; rd_n = 1; mode_sel = 2'b11;
    for (int i = 0; i < 3; i++) tx_buf[i] = 8'($urandom);
    write_burst(7'h10, 3);
    read_burst(7'h10, 3, "R2");

    // R10 abort inside command byte, then full write must align
    do_reset(1, 0, 1, 0, 0);
    w0 = we_count;
    cs_pin = cur_csh; wait_clk(H);
    xfer(8'h7F, 3, r);
    cs_pin = !cur_csh; sclk = cur_cpol; wait_clk(2*H);
    tx_buf[0] = 8'h3C;
    write_burst(7'h22, 1);
    wait_clk(2);
    check(mem[7'h22] == 8'h3C, "R10", mem[7'h22], 8'h3C);
    // R10 abort inside a write data byte: no write
    w0 = we_count;
    cs_pin = cur_csh; wait_clk(H);
    xfer(8'h22, 8, r);
    xfer(8'hFF, 5, r);
    cs_pin = !cur_csh; sclk = cur_cpol; wait_clk(2*H);
    check(we_count == w0, "R10", we_count - w0, 0);
    read_burst(7'h22, 1, "R10");

    // R1 disabled by strobe strap, then by mode strap
    for (int m = 0; m < 2; m++) begin
      do_reset(m == 0 ? 0 : 1, 0, 0, 0, 0);
      if (m == 1) begin
        @(negedge clk); rst_n = 0; mode_sel = 2'b01; wait_clk(3); rst_n = 1; wait_clk(3);
      end
      w0 = we_count;
      cs_pin = cur_csh; wait_clk(H);
      check(miso_oe == 1'b0, "R1", miso_oe, 0);
      xfer(8'h05, 8, r);
      xfer(8'hEE, 8, r);
      cs_pin = !cur_csh; wait_clk(2*H);
      check(we_count == w0, "R1", we_count - w0, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule